// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Sequencer

This block turns a train of timing events into four gate-drive signals for a full bridge, arranged as a high-side and a low-side output for each of the two legs. In the usual setup the events are edges of a zero-crossing signal taken from the load current. Each selected edge ends one half-cycle of the bridge and starts the next, so the bridge switches at half the event rate. One leg, the lead leg, changes state right at the half-cycle boundary. The other leg, the delayed leg, changes state a programmable number of clock cycles later. The overlap between the two legs sets how much power reaches the load. Each transition of a leg is followed by a programmable dead time, during which both of that leg's outputs stay low.

An overcurrent kill input blanks the drive for the rest of the current half-cycle without disturbing the half-cycle bookkeeping. The next boundary therefore arrives on schedule and the drive resumes. In an alternating mode the roles of the two legs swap every full cycle, which shares the harder switching duty between them. An internal timebase can replace the external events: a fixed half-period in clock cycles then drives the sequence. A watchdog on the external events shuts the drive down and raises a flag if the events stop.

Top module: `bridge_gate_seq`

## Requirements
- R1: After reset all four gate outputs and the timeout flag are low. The first selected event starts an even half-cycle. In an even half-cycle leg A drives its high side and leg B drives its low side, once the dead time has passed.
- R2: With `trigRiseSel` = 1 a half-cycle boundary occurs on a 0-to-1 change of `trigIn`. With `trigRiseSel` = 0 it occurs on a 1-to-0 change. A change in the other direction has no effect on the outputs.
- R3: Each boundary starts a new half-cycle, and the half-cycles alternate between even and odd. The lead leg changes state at the boundary. Leg A's high side belongs to even half-cycles and its low side to odd ones. Leg B is the reverse.
- R4: After any change of state of a leg, both outputs of that leg stay low until `deadTime` clock cycles have passed since the change.
- R5: The delayed leg changes state when the count of cycles since the boundary reaches the effective delay. Before that point it keeps the state it had in the previous half-cycle. In the first half-cycle after a start, the delayed leg stays low before that point.
- R6: The effective delay equals `phaseDelay`, limited to at most L − `deadTime` − 1, where L is the measured length of the previous half-cycle in clock cycles. The effective delay is 0 when L ≤ `deadTime`, which includes the first half-cycle after a start.
- R7: `killIn` is sampled on the clock edge. From the following cycle, all four gates stay low until the next boundary. A kill that is sampled on the boundary edge blanks the whole new half-cycle. Boundaries keep their timing while a kill is in effect.
- R8: With `altShiftEn` = 1, the leg roles swap at each entry into an even half-cycle, so that leg A becomes the delayed leg on alternate full cycles. With `altShiftEn` = 0, leg A is the lead leg from the next even half-cycle on.
- R9: With `useIntTime` = 1, the sequence starts without any event and each half-cycle lasts `intHalfPeriod` clock cycles. `trigIn` is then ignored.
- R10: In external mode, once `timeoutLimit` cycles have passed since the last boundary without a new event, all gates go low and `trigTimeout` goes high. The next event clears the flag and starts a fresh sequence, as in R1, R5 and R6.
- R11: The high side and the low side of one leg are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Zero-crossing event input |
| trigRiseSel | input | 1 | 1: rising edges are boundaries, 0: falling edges |
| useIntTime | input | 1 | 1: internal timebase, 0: external events |
| intHalfPeriod | input | CNT_W | Half-cycle length in internal mode, in cycles |
| phaseDelay | input | CNT_W | Requested delay of the delayed leg, in cycles |
| deadTime | input | CNT_W | Dead time after each leg transition, in cycles |
| timeoutLimit | input | CNT_W | Cycles without an event before shutdown |
| altShiftEn | input | 1 | Swap the leg roles every full cycle |
| killIn | input | 1 | Overcurrent kill, blanks the current half-cycle |
| gateAHi | output | 1 | Leg A high-side gate |
| gateALo | output | 1 | Leg A low-side gate |
| gateBHi | output | 1 | Leg B high-side gate |
| gateBLo | output | 1 | Leg B low-side gate |
| trigTimeout | output | 1 | Set when the events have stopped |

## Verification
The critical overlap is a kill that is sampled on the same clock edge as a half-cycle boundary. The new half-cycle must then be blanked in full, and the boundary after it must still fall in its normal cycle. The bench provokes this by raising `killIn` in the cycle just before a known trigger edge. It then checks that all gates are low early in the new half-cycle and that the normal drive pattern returns at a fixed offset in the following half-cycle. A second overlap is a leg-role swap that falls on the same boundary as a dead-time window. It is judged by sampling both legs just before and just after their transition points in the swapped cycle.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  parameter int unsigned CNT_W = 12;

  typedef struct packed {
    logic             run;
    logic             halfSel;
    logic             altSel;
    logic             kill;
    logic             primed;
    logic [CNT_W-1:0] hcCnt;
    logic [CNT_W-1:0] lastLen;
  } seq_state_t;
endpackage

// File: rtl/bgs_ctrl.sv
module bgs_ctrl
  import bgs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigIn,
  input  logic             trigRiseSel,
  input  logic             useIntTime,
  input  logic [CNT_W-1:0] intHalfPeriod,
  input  logic [CNT_W-1:0] timeoutLimit,
  input  logic             altShiftEn,
  input  logic             killIn,
  output seq_state_t       st,
  output logic             trigTimeout
);
  localparam int unsigned W1 = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic trigQ, runQ, halfQ, altQ, killQ, primedQ, tmoQ;
  logic [CNT_W-1:0] hcCnt, lastLen;
  logic edgeSeen, intWrap, bound, tmoHit;

  always_comb begin
    edgeSeen = trigRiseSel ? (trigIn & ~trigQ) : (~trigIn & trigQ);
    intWrap  = runQ && (({1'b0, hcCnt} + W1'(1)) >= {1'b0, intHalfPeriod});
    bound    = useIntTime ? (!runQ || intWrap) : edgeSeen;
    tmoHit   = runQ && !useIntTime && (hcCnt >= timeoutLimit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trigQ   <= 1'b0;
      runQ    <= 1'b0;
      halfQ   <= 1'b0;
      altQ    <= 1'b0;
      killQ   <= 1'b0;
      primedQ <= 1'b0;
      tmoQ    <= 1'b0;
      hcCnt   <= '0;
      lastLen <= '0;
    end else begin
      trigQ <= trigIn;
      if (bound) begin
        runQ  <= 1'b1;
        hcCnt <= '0;
        killQ <= killIn;
        tmoQ  <= 1'b0;
        if (!runQ) begin
          halfQ   <= 1'b0;
          altQ    <= 1'b0;
          primedQ <= 1'b0;
          lastLen <= '0;
        end else begin
          halfQ   <= ~halfQ;
          primedQ <= 1'b1;
          lastLen <= (hcCnt == CNT_MAX) ? CNT_MAX : hcCnt + CNT_W'(1);
          if (halfQ) altQ <= altShiftEn ? ~altQ : 1'b0;
        end
      end else if (tmoHit) begin
        runQ  <= 1'b0;
        tmoQ  <= 1'b1;
        killQ <= 1'b0;
      end else begin
        if (hcCnt != CNT_MAX) hcCnt <= hcCnt + CNT_W'(1);
        if (killIn) killQ <= 1'b1;
      end
    end
  end

  always_comb begin
    st.run     = runQ;
    st.halfSel = halfQ;
    st.altSel  = altQ;
    st.kill    = killQ;
    st.primed  = primedQ;
    st.hcCnt   = hcCnt;
    st.lastLen = lastLen;
  end
  assign trigTimeout = tmoQ;

  // R3
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bound && runQ) |=> (halfQ != $past(halfQ)));

  // R10
  timeout_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmoQ |-> !runQ);
endmodule

// File: rtl/bgs_datapath.sv
module bgs_datapath
  import bgs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_t       st,
  input  logic [CNT_W-1:0] phaseDelay,
  input  logic [CNT_W-1:0] deadTime,
  output logic [1:0]       legHi,
  output logic [1:0]       legLo
);
  localparam int unsigned NUM_LEGS = 2;

  logic [CNT_W-1:0] clampLim, effDelay;
  logic pastDelay, leadPh, delPh, leadOk, delOk, drvEn;

  always_comb begin
    clampLim  = (st.lastLen > deadTime) ? (st.lastLen - deadTime - CNT_W'(1)) : '0;
    effDelay  = (phaseDelay > clampLim) ? clampLim : phaseDelay;
    pastDelay = st.hcCnt >= effDelay;
    leadPh    = st.halfSel;
    delPh     = pastDelay ? st.halfSel : ~st.halfSel;
    leadOk    = st.hcCnt >= deadTime;
    delOk     = pastDelay ? ((st.hcCnt - effDelay) >= deadTime) : st.primed;
    drvEn     = st.run && !st.kill;
  end

  for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
    localparam logic HI_PH = (i == 1);
    logic isDel, ph, ok;
    // two-AND-into-OR steering between lead and delayed drive
    assign isDel = st.altSel ? (i == 0) : (i == 1);
    assign ph    = (isDel & delPh) | (~isDel & leadPh);
    assign ok    = (isDel & delOk) | (~isDel & leadOk);
    assign legHi[i] = drvEn && ok && (ph == HI_PH);
    assign legLo[i] = drvEn && ok && (ph != HI_PH);

    // R11
    leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(legHi[i] && legLo[i]));

    // R4
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deadTime != '0 && $stable(deadTime) && $stable(phaseDelay) && $rose(legHi[i]))
        |-> !$past(legLo[i]));
  end
endmodule

// File: rtl/bridge_gate_seq.sv
module bridge_gate_seq
  import bgs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigIn,
  input  logic             trigRiseSel,
  input  logic             useIntTime,
  input  logic [CNT_W-1:0] intHalfPeriod,
  input  logic [CNT_W-1:0] phaseDelay,
  input  logic [CNT_W-1:0] deadTime,
  input  logic [CNT_W-1:0] timeoutLimit,
  input  logic             altShiftEn,
  input  logic             killIn,
  output logic             gateAHi,
  output logic             gateALo,
  output logic             gateBHi,
  output logic             gateBLo,
  output logic             trigTimeout
);
  seq_state_t seqSt;
  logic [1:0] legHi, legLo;

  bgs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .trigIn(trigIn), .trigRiseSel(trigRiseSel),
    .useIntTime(useIntTime), .intHalfPeriod(intHalfPeriod),
    .timeoutLimit(timeoutLimit), .altShiftEn(altShiftEn), .killIn(killIn),
    .st(seqSt), .trigTimeout(trigTimeout)
  );

  bgs_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .st(seqSt), .phaseDelay(phaseDelay),
    .deadTime(deadTime), .legHi(legHi), .legLo(legLo)
  );

  assign gateAHi = legHi[0];
  assign gateALo = legLo[0];
  assign gateBHi = legHi[1];
  assign gateBLo = legLo[1];

  // R7
  kill_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    killIn |=> !(gateAHi || gateALo || gateBHi || gateBLo));
endmodule

// File: tb/bridge_gate_seq_tb.sv
`timescale 1ns/1ps
module bridge_gate_seq_tb;
  import bgs_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, trigRiseSel, useIntTime, altShiftEn, killIn;
  logic [CNT_W-1:0] intHalfPeriod, phaseDelay, deadTime, timeoutLimit;
  logic gateAHi, gateALo, gateBHi, gateBLo, trigTimeout;
  logic genEn, genTrig, manTrig, trigIn;
  int genCnt, halfCnt, nChk, nFail;
  bit done;

  assign trigIn = genEn ? genTrig : manTrig;

  bridge_gate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .trigIn(trigIn), .trigRiseSel(trigRiseSel),
    .useIntTime(useIntTime), .intHalfPeriod(intHalfPeriod),
    .phaseDelay(phaseDelay), .deadTime(deadTime), .timeoutLimit(timeoutLimit),
    .altShiftEn(altShiftEn), .killIn(killIn), .gateAHi(gateAHi),
    .gateALo(gateALo), .gateBHi(gateBHi), .gateBLo(gateBLo),
    .trigTimeout(trigTimeout)
  );

  // event generator: rising edge every 20 cycles, falling edge 10 cycles later
  always @(negedge clk) begin
    if (genEn) begin
      if (genCnt == 0) begin
        genTrig <= 1'b1;
        halfCnt <= halfCnt + 1;
      end
      if (genCnt == 10) genTrig <= 1'b0;
      genCnt <= (genCnt == 19) ? 0 : genCnt + 1;
    end
  end

  // rows: {par, j, expected {AHi,ALo,BHi,BLo}}, delay 5, dead 2, half length 20
  localparam logic [9:0] VEC [11] = '{
    {1'b0, 5'd0,  4'b0010}, {1'b0, 5'd1,  4'b0010}, {1'b0, 5'd2,  4'b1010},
    {1'b0, 5'd5,  4'b1000}, {1'b0, 5'd6,  4'b1000}, {1'b0, 5'd7,  4'b1001},
    {1'b0, 5'd15, 4'b1001}, {1'b1, 5'd0,  4'b0001}, {1'b1, 5'd2,  4'b0101},
    {1'b1, 5'd5,  4'b0100}, {1'b1, 5'd7,  4'b0110}
  };

  task automatic chk(input logic [3:0] exp, input string tag);
    logic [3:0] got;
    got = {gateAHi, gateALo, gateBHi, gateBLo};
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s gates got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chkFlag(input logic exp, input string tag);
    nChk++;
    if (trigTimeout !== exp) begin
      nFail++;
      $display("FAIL %s timeout flag got %b expected %b", tag, trigTimeout, exp);
    end
  endtask

  // wait for the negedge at cycle j of a steady half-cycle of parity par
  task automatic waitFor(input logic par, input int j);
    do @(negedge clk);
    while (!(genCnt == j + 1 && halfCnt[0] != par && halfCnt >= 3));
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired got running expected finished");
    finishRun();
  end

  initial begin
    nChk = 0; nFail = 0; done = 1'b0;
    genEn = 1'b0; genTrig = 1'b0; genCnt = 0; halfCnt = 0; manTrig = 1'b0;
    trigRiseSel = 1'b1; useIntTime = 1'b0; altShiftEn = 1'b0; killIn = 1'b0;
    intHalfPeriod = 16; phaseDelay = 5; deadTime = 2; timeoutLimit = 30;
    doReset();
    @(negedge clk);
    chk(4'b0000, "R1 reset state");
    chkFlag(1'b0, "R1 reset flag");

    // R2: falling-edge selection ignores the rising edge
    trigRiseSel = 1'b0;
    doReset();
    manTrig = 1'b1;
    repeat (5) @(negedge clk);
    chk(4'b0000, "R2 rising edge ignored in falling mode");
    manTrig = 1'b0;
    repeat (4) @(negedge clk);
    chk(4'b1001, "R2 R1 falling edge starts even half");

    // steady external run
    trigRiseSel = 1'b1;
    doReset();
    @(negedge clk);
    genEn = 1'b1;
    for (int k = 0; k < 11; k++) begin
      waitFor(VEC[k][9], int'(VEC[k][8:4]));
      chk(VEC[k][3:0], $sformatf("table R3 R4 R5 row %0d", k));
    end

    // R7: kill mid half-cycle
    waitFor(1'b0, 10);
    killIn = 1'b1;
    @(negedge clk);
    killIn = 1'b0;
    chk(4'b0000, "R7 kill blanks next cycle");
    waitFor(1'b0, 18);
    chk(4'b0000, "R7 kill holds to boundary");
    waitFor(1'b1, 2);
    chk(4'b0101, "R7 drive resumes after boundary");
    waitFor(1'b1, 7);
    chk(4'b0110, "R7 timebase kept");

    // R7: kill on the boundary edge
    do @(negedge clk); while (!(genCnt == 0 && halfCnt[0] == 1'b0));
    chk(4'b0110, "R7 pre-boundary drive");
    killIn = 1'b1;
    @(negedge clk);
    killIn = 1'b0;
    chk(4'b0000, "R7 boundary kill start");
    waitFor(1'b0, 5);
    chk(4'b0000, "R7 boundary kill whole half");
    waitFor(1'b1, 8);
    chk(4'b0110, "R7 after boundary kill");

    // R8: alternating leg roles
    waitFor(1'b1, 5);
    altShiftEn = 1'b1;
    waitFor(1'b0, 3);
    chk(4'b0101, "R8 swapped lead at j3");
    waitFor(1'b0, 8);
    chk(4'b1001, "R8 swapped delayed leg A");
    waitFor(1'b1, 3);
    chk(4'b1010, "R8 swapped odd half");
    waitFor(1'b0, 3);
    chk(4'b1010, "R8 roles back next cycle");
    altShiftEn = 1'b0;
    waitFor(1'b0, 3);
    chk(4'b1010, "R8 disabled A leads");

    // R6: clamp
    waitFor(1'b1, 10);
    phaseDelay = 30;
    waitFor(1'b0, 16);
    chk(4'b1010, "R6 before clamped delay");
    waitFor(1'b0, 17);
    chk(4'b1000, "R6 clamped delay reached");
    waitFor(1'b1, 1);
    phaseDelay = 5;

    // R10: timeout
    waitFor(1'b1, 12);
    genEn = 1'b0;
    repeat (45) @(negedge clk);
    chk(4'b0000, "R10 outputs off after timeout");
    chkFlag(1'b1, "R10 flag set");
    manTrig = 1'b1;
    @(negedge clk);
    chk(4'b0000, "R10 restart dead time");
    chkFlag(1'b0, "R10 flag cleared");
    repeat (3) @(negedge clk);
    chk(4'b1001, "R10 R5 fresh start first half");

    // R9: internal timebase
    manTrig = 1'b0;
    doReset();
    useIntTime = 1'b1;
    @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      manTrig = ~manTrig;
    end
    chk(4'b1001, "R9 internal first half");
    repeat (16) begin
      @(negedge clk);
      manTrig = ~manTrig;
    end
    chk(4'b0101, "R9 internal second half");
    repeat (16) @(negedge clk);
    chk(4'b1010, "R9 internal third half");

    finishRun();
  end
endmodule